// File: doc/BRIEF.md
# General-Purpose Pin Port Controller

This block controls a bank of general-purpose pins through a word-addressed register interface. Software writes an output-value register and a direction register, either whole or through set and clear aliases. A small configuration word per pin carries that pin's direction bit and an input-buffer disconnect bit. The direction bit in each configuration word and the matching bit of the direction register are one and the same state.

For every pin, three controls can be taken over by another peripheral on the chip, each on its own: the direction, the output value and the input buffer. Each takeover comes with its own value or connect flag. The block combines the register state with these takeover requests to drive the pad output value and output enable. It also records the pad levels into an input register, masked by the effective input enable. External pad levels pass through a synchroniser first. A pin that the block drives reads back its own driven level.

Top module: `pin_port`

## Requirements
- R1: Word 0 holds the output register. A write to word 1 ORs the written mask into it. A write to word 2 clears the masked bits in it.
- R2: Word 4 holds the direction register. A write to word 5 ORs the written mask into it. A write to word 6 clears the masked bits in it.
- R3: The read data is registered and is valid one clock after the address is presented. Words 1 and 5 read back the output and direction registers. Words 2 and 6 always read zero.
- R4: Word 8+n is the configuration of pin n. Bit 0 is its direction bit and bit 1 its input-disconnect bit. Bit 0 always equals bit n of the direction register, whether the direction was written through words 4, 5 or 6 or through the configuration word.
- R5: After reset the output and direction registers are zero, every configuration word reads 0x2, the input register is zero and no pad is driven.
- R6: The effective direction, which is pad_oe, is the direction bit where ovr_dir_own is 0. Where ovr_dir_own is 1 it is ovr_dir_con.
- R7: The effective output value is the output register bit where ovr_out_own is 0, and ovr_out_val where it is 1. pad_o carries that value where pad_oe is 1 and is 0 elsewhere.
- R8: The input enable is the inverse of configuration bit 1 where ovr_in_own is 0, and ovr_in_con where it is 1. The input register holds the pin level ANDed with the input enable. A change on pad_i of an undriven pin reaches the input register on the third rising edge.
- R9: A pin with pad_oe at 1 records its own pad_o level, one edge after that level changes, and pad_i on that pin has no effect.
- R10: Writes to word 3 (input register) and word 7 (unused) change no state. Word 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the word at addr |
| addr | input | ADDR_W (6) | Word address for write and read |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Registered read data for the previous cycle's addr |
| ovr_dir_own | input | NPINS (32) | Peripheral owns the pin direction |
| ovr_dir_con | input | NPINS (32) | Peripheral direction: 1 drives the pad |
| ovr_out_own | input | NPINS (32) | Peripheral owns the output value |
| ovr_out_val | input | NPINS (32) | Peripheral output value |
| ovr_in_own | input | NPINS (32) | Peripheral owns the input buffer |
| ovr_in_con | input | NPINS (32) | Peripheral input connect flag |
| pad_i | input | NPINS (32) | Level seen on each pad from outside |
| pad_o | output | NPINS (32) | Output value to each pad |
| pad_oe | output | NPINS (32) | Output enable of each pad |

## Verification
Register writes land on the edge that samples the strobe. Reads appear one edge after the address. pad_o and pad_oe follow the registers and the takeover inputs with no added register. A driven level enters the input register one edge later, and an external level three edges later. The bench drives and samples on falling edges. It checks the input-register latency with the read address held: the old value must still be there one edge before the due edge, and the new value must appear on it. The combinational pad results are checked shortly after the inputs change.

// File: rtl/pin_port_pkg.sv
package pin_port_pkg;

  localparam int unsigned WORD_W = 32;

  // Word addresses of the port registers
  localparam int unsigned A_OUT    = 0;
  localparam int unsigned A_OUTSET = 1;
  localparam int unsigned A_OUTCLR = 2;
  localparam int unsigned A_IN     = 3;
  localparam int unsigned A_DIR    = 4;
  localparam int unsigned A_DIRSET = 5;
  localparam int unsigned A_DIRCLR = 6;
  localparam int unsigned A_RSVD   = 7;
  localparam int unsigned CFG_BASE = 8;

  // Configuration word bit positions
  localparam int unsigned CFG_DIR_BIT   = 0;
  localparam int unsigned CFG_INDIS_BIT = 1;

  typedef enum logic [1:0] {
    UPD_KEEP,
    UPD_LOAD,
    UPD_SET,
    UPD_CLR
  } upd_e;

  function automatic logic [WORD_W-1:0] apply_upd(input upd_e op,
                                                  input logic [WORD_W-1:0] cur,
                                                  input logic [WORD_W-1:0] val);
    case (op)
      UPD_LOAD: return val;
      UPD_SET:  return cur | val;
      UPD_CLR:  return cur & ~val;
      default:  return cur;
    endcase
  endfunction

endpackage

// File: rtl/pin_port_regs.sv
module pin_port_regs
  import pin_port_pkg::*;
#(
  parameter int unsigned NPINS  = 32,
  parameter int unsigned ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [NPINS-1:0]  out_q,
  output logic [NPINS-1:0]  dir_q,
  output logic [NPINS-1:0]  indis_q
);

  localparam int unsigned PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  logic [ADDR_W-1:0] offs;
  logic              cfg_hit;
  upd_e              out_op;
  upd_e              dir_op;
  logic [WORD_W-1:0] out_ext;
  logic [WORD_W-1:0] dir_ext;
  logic [NPINS-1:0]  out_d;
  logic [NPINS-1:0]  dir_d;
  logic [NPINS-1:0]  indis_d;

  assign offs    = addr - ADDR_W'(CFG_BASE);
  assign cfg_hit = (addr >= ADDR_W'(CFG_BASE)) && (offs < ADDR_W'(NPINS));
  assign out_ext = WORD_W'(out_q);
  assign dir_ext = WORD_W'(dir_q);

  always_comb begin
    out_op = UPD_KEEP;
    dir_op = UPD_KEEP;
    if (wr_en) begin
      case (addr)
        ADDR_W'(A_OUT):    out_op = UPD_LOAD;
        ADDR_W'(A_OUTSET): out_op = UPD_SET;
        ADDR_W'(A_OUTCLR): out_op = UPD_CLR;
        ADDR_W'(A_DIR):    dir_op = UPD_LOAD;
        ADDR_W'(A_DIRSET): dir_op = UPD_SET;
        ADDR_W'(A_DIRCLR): dir_op = UPD_CLR;
        default: begin
          out_op = UPD_KEEP;
          dir_op = UPD_KEEP;
        end
      endcase
    end
  end

  always_comb begin
    out_d   = NPINS'(apply_upd(out_op, out_ext, wdata));
    dir_d   = NPINS'(apply_upd(dir_op, dir_ext, wdata));
    indis_d = indis_q;
    if (wr_en && cfg_hit) begin
      dir_d[offs[PIN_W-1:0]]   = wdata[CFG_DIR_BIT];
      indis_d[offs[PIN_W-1:0]] = wdata[CFG_INDIS_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_q   <= '0;
      dir_q   <= '0;
      indis_q <= '1;
    end else begin
      out_q   <= out_d;
      dir_q   <= dir_d;
      indis_q <= indis_d;
    end
  end

  AST_OUTSET_OR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(A_OUTSET)) |=> out_q == ($past(out_q) | $past(wdata[NPINS-1:0]))); // R1
  AST_OUTCLR_AND: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(A_OUTCLR)) |=> out_q == ($past(out_q) & ~$past(wdata[NPINS-1:0]))); // R1
  AST_DIRSET_OR: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(A_DIRSET)) |=> dir_q == ($past(dir_q) | $past(wdata[NPINS-1:0]))); // R2
  AST_DIRCLR_AND: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == ADDR_W'(A_DIRCLR)) |=> dir_q == ($past(dir_q) & ~$past(wdata[NPINS-1:0]))); // R2
  AST_RESET_CFG: assert property (@(posedge clk)
    rst |=> (dir_q == '0 && out_q == '0 && indis_q == '1)); // R5
  AST_IGNORED_WRITE: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (addr == ADDR_W'(A_IN) || addr == ADDR_W'(A_RSVD)))
      |=> ($stable(out_q) && $stable(dir_q) && $stable(indis_q))); // R10

endmodule

// File: rtl/pin_port_route.sv
module pin_port_route #(
  parameter int unsigned NPINS = 32
) (
  input  logic [NPINS-1:0] out_q,
  input  logic [NPINS-1:0] dir_q,
  input  logic [NPINS-1:0] indis_q,
  input  logic [NPINS-1:0] ovr_dir_own,
  input  logic [NPINS-1:0] ovr_dir_con,
  input  logic [NPINS-1:0] ovr_out_own,
  input  logic [NPINS-1:0] ovr_out_val,
  input  logic [NPINS-1:0] ovr_in_own,
  input  logic [NPINS-1:0] ovr_in_con,
  output logic [NPINS-1:0] pad_o,
  output logic [NPINS-1:0] pad_oe,
  output logic [NPINS-1:0] in_en
);

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    logic eff_dir;
    logic eff_out;
    assign eff_dir  = ovr_dir_own[p] ? ovr_dir_con[p] : dir_q[p];
    assign eff_out  = ovr_out_own[p] ? ovr_out_val[p] : out_q[p];
    assign pad_oe[p] = eff_dir;
    assign pad_o[p]  = eff_out & eff_dir;
    assign in_en[p]  = ovr_in_own[p] ? ovr_in_con[p] : ~indis_q[p];
  end

endmodule

// File: rtl/pin_port_sample.sv
module pin_port_sample #(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [NPINS-1:0] pad_i,
  input  logic [NPINS-1:0] pad_o,
  input  logic [NPINS-1:0] pad_oe,
  input  logic [NPINS-1:0] in_en,
  output logic [NPINS-1:0] in_q
);

  logic [SYNC_STAGES-1:0][NPINS-1:0] sync_q;
  logic [NPINS-1:0]                  ext_lvl;
  logic [NPINS-1:0]                  pin_lvl;

  if (SYNC_STAGES == 1) begin : g_sync_one
    always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q[0] <= pad_i;
    end
  end else begin : g_sync_chain
    always_ff @(posedge clk) begin
      if (rst) sync_q <= '0;
      else     sync_q <= {sync_q[SYNC_STAGES-2:0], pad_i};
    end
  end

  assign ext_lvl = sync_q[SYNC_STAGES-1];
  assign pin_lvl = (pad_oe & pad_o) | (~pad_oe & ext_lvl);

  always_ff @(posedge clk) begin
    if (rst) in_q <= '0;
    else     in_q <= pin_lvl & in_en;
  end

  AST_IN_MASKED: assert property (@(posedge clk) disable iff (rst)
    (in_q & ~$past(in_en)) == '0); // R8
  AST_DRIVEN_ECHO: assert property (@(posedge clk) disable iff (rst)
    ((in_q ^ $past(pad_o)) & $past(pad_oe & in_en)) == '0); // R9

endmodule

// File: rtl/pin_port.sv
module pin_port
  import pin_port_pkg::*;
#(
  parameter int unsigned NPINS       = 32,
  parameter int unsigned ADDR_W      = 6,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic [NPINS-1:0]  ovr_dir_own,
  input  logic [NPINS-1:0]  ovr_dir_con,
  input  logic [NPINS-1:0]  ovr_out_own,
  input  logic [NPINS-1:0]  ovr_out_val,
  input  logic [NPINS-1:0]  ovr_in_own,
  input  logic [NPINS-1:0]  ovr_in_con,
  input  logic [NPINS-1:0]  pad_i,
  output logic [NPINS-1:0]  pad_o,
  output logic [NPINS-1:0]  pad_oe
);

  localparam int unsigned PIN_W = (NPINS > 1) ? $clog2(NPINS) : 1;

  logic [NPINS-1:0]  out_q;
  logic [NPINS-1:0]  dir_q;
  logic [NPINS-1:0]  indis_q;
  logic [NPINS-1:0]  in_en;
  logic [NPINS-1:0]  in_q;
  logic [ADDR_W-1:0] offs;
  logic              cfg_hit;
  logic [WORD_W-1:0] rd_d;

  pin_port_regs #(.NPINS(NPINS), .ADDR_W(ADDR_W)) i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .out_q(out_q), .dir_q(dir_q), .indis_q(indis_q)
  );

  pin_port_route #(.NPINS(NPINS)) i_route (
    .out_q(out_q), .dir_q(dir_q), .indis_q(indis_q),
    .ovr_dir_own(ovr_dir_own), .ovr_dir_con(ovr_dir_con),
    .ovr_out_own(ovr_out_own), .ovr_out_val(ovr_out_val),
    .ovr_in_own(ovr_in_own), .ovr_in_con(ovr_in_con),
    .pad_o(pad_o), .pad_oe(pad_oe), .in_en(in_en)
  );

  pin_port_sample #(.NPINS(NPINS), .SYNC_STAGES(SYNC_STAGES)) i_sample (
    .clk(clk), .rst(rst), .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe),
    .in_en(in_en), .in_q(in_q)
  );

  assign offs    = addr - ADDR_W'(CFG_BASE);
  assign cfg_hit = (addr >= ADDR_W'(CFG_BASE)) && (offs < ADDR_W'(NPINS));

  always_comb begin
    rd_d = '0;
    case (addr)
      ADDR_W'(A_OUT), ADDR_W'(A_OUTSET): rd_d = WORD_W'(out_q);
      ADDR_W'(A_DIR), ADDR_W'(A_DIRSET): rd_d = WORD_W'(dir_q);
      ADDR_W'(A_IN):                     rd_d = WORD_W'(in_q);
      default: begin
        if (cfg_hit) begin
          rd_d[CFG_DIR_BIT]   = dir_q[offs[PIN_W-1:0]];
          rd_d[CFG_INDIS_BIT] = indis_q[offs[PIN_W-1:0]];
        end
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rd_d;
  end

  AST_CLR_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (addr == ADDR_W'(A_OUTCLR) || addr == ADDR_W'(A_DIRCLR)) |=> rdata == '0); // R3
  AST_OWNED_DIR: assert property (@(posedge clk) disable iff (rst)
    ((pad_oe ^ ovr_dir_con) & ovr_dir_own) == '0); // R6
  AST_OWNED_OUT: assert property (@(posedge clk) disable iff (rst)
    ((pad_o ^ ovr_out_val) & ovr_out_own & pad_oe) == '0); // R7
  AST_UNDRIVEN_LOW: assert property (@(posedge clk) disable iff (rst)
    (pad_o & ~pad_oe) == '0); // R7

endmodule

// File: tb/test_pin_port.sv
module test_pin_port;

  localparam int NP = 32;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] ovr_dir_own = '0, ovr_dir_con = '0;
  logic [NP-1:0] ovr_out_own = '0, ovr_out_val = '0;
  logic [NP-1:0] ovr_in_own = '0, ovr_in_con = '0;
  logic [NP-1:0] pad_i = '0;
  logic [NP-1:0] pad_o, pad_oe;

  int checks = 0;
  int failures = 0;

  always #5 clk = ~clk;

  pin_port #(.NPINS(NP), .ADDR_W(AW), .SYNC_STAGES(2)) i_pin_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
    .ovr_dir_own(ovr_dir_own), .ovr_dir_con(ovr_dir_con),
    .ovr_out_own(ovr_out_own), .ovr_out_val(ovr_out_val),
    .ovr_in_own(ovr_in_own), .ovr_in_con(ovr_in_con),
    .pad_i(pad_i), .pad_o(pad_o), .pad_oe(pad_oe)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [5:0]  waddr;
    logic [31:0] wdata;
    logic [5:0]  raddr;
    logic [31:0] exp;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{4'd1,  6'd0,  32'h0000_00F0, 6'd0,  32'h0000_00F0}, // R1 load
    '{4'd1,  6'd1,  32'h0F00_000F, 6'd0,  32'h0F00_00FF}, // R1 set
    '{4'd1,  6'd2,  32'h0000_00F0, 6'd0,  32'h0F00_000F}, // R1 clear
    '{4'd3,  6'd2,  32'h0000_0001, 6'd2,  32'h0000_0000}, // R3 clear alias reads 0
    '{4'd3,  6'd1,  32'h0000_0000, 6'd1,  32'h0F00_000E}, // R3 set alias reads OUT
    '{4'd2,  6'd4,  32'h0000_0011, 6'd4,  32'h0000_0011}, // R2 load
    '{4'd2,  6'd5,  32'h0000_0100, 6'd5,  32'h0000_0111}, // R2 set, alias reads DIR
    '{4'd2,  6'd6,  32'h0000_0001, 6'd4,  32'h0000_0110}, // R2 clear
    '{4'd3,  6'd6,  32'h0000_0000, 6'd6,  32'h0000_0000}, // R3 clear alias reads 0
    '{4'd10, 6'd3,  32'hFFFF_FFFF, 6'd0,  32'h0F00_000E}, // R10 write to IN
    '{4'd4,  6'd7,  32'hFFFF_FFFF, 6'd12, 32'h0000_0003}, // R4 cfg pin4 mirrors DIR
    '{4'd4,  6'd12, 32'h0000_0000, 6'd4,  32'h0000_0100}, // R4 cfg write clears DIR bit
    '{4'd4,  6'd8,  32'h0000_0001, 6'd8,  32'h0000_0001}, // R4 cfg pin0
    '{4'd4,  6'd4,  32'h0000_0000, 6'd8,  32'h0000_0000}  // R4 DIR write reaches cfg
  };

  function automatic string rname(input logic [3:0] r);
    case (r)
      4'd1:  return "R1";
      4'd2:  return "R2";
      4'd3:  return "R3";
      4'd4:  return "R4";
      4'd10: return "R10";
      default: return "R?";
    endcase
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    addr = a;
    @(negedge clk);
    d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rst = 1'b0;
    @(negedge clk);

    // R5 reset state
    rd(6'd0, v);  check("R5 OUT", v, 32'h0);
    rd(6'd39, v); check("R5 cfg pin31", v, 32'h2);
    rd(6'd3, v);  check("R5 IN", v, 32'h0);
    check("R5 pad_oe", pad_oe, 32'h0);

    for (int k = 0; k < NV; k++) begin
      wr(VECS[k].waddr, VECS[k].wdata);
      rd(VECS[k].raddr, v);
      check(rname(VECS[k].req), v, VECS[k].exp);
    end

    rd(6'd7, v); check("R10 unused word reads 0", v, 32'h0);

    // R6 / R7 pad drive, OUT = 0F00_000E
    wr(6'd4, 32'h0000_000C);
    check("R6 pad_oe from DIR", pad_oe, 32'h0000_000C);
    check("R7 pad_o from OUT", pad_o, 32'h0000_000C);
    ovr_dir_own = 32'h24; ovr_dir_con = 32'h20;
    #1;
    check("R6 pad_oe overridden", pad_oe, 32'h0000_0028);
    check("R7 pad_o masked by oe", pad_o, 32'h0000_0008);
    ovr_out_own = 32'h28; ovr_out_val = 32'h20;
    #1;
    check("R7 pad_o overridden", pad_o, 32'h0000_0020);
    @(negedge clk);
    ovr_dir_own = '0; ovr_dir_con = '0; ovr_out_own = '0; ovr_out_val = '0;

    // R8 input enable; pins 0 and 4 connected
    pad_i = 32'h0000_0011;
    idle(4);
    rd(6'd3, v); check("R8 IN connected pins", v, 32'h0000_0011);
    pad_i = '1;
    idle(4);
    rd(6'd3, v); check("R8 disconnected pins masked", v, 32'h0000_0011);
    ovr_in_own = 32'h81; ovr_in_con = 32'h80;
    idle(2);
    rd(6'd3, v); check("R8 input override", v, 32'h0000_0090);
    ovr_in_own = '0; ovr_in_con = '0;

    // R9 driven pin echoes its own level
    wr(6'd10, 32'h0000_0001);
    pad_i = '0;
    idle(4);
    rd(6'd3, v); check("R9 driven pin reads own 1", v, 32'h0000_0004);
    ovr_out_own = 32'h4; ovr_out_val = 32'h0; pad_i = 32'h4;
    @(negedge clk); check("R9 not yet", rdata, 32'h0000_0004);
    @(negedge clk); check("R9 echo after one edge", rdata, 32'h0000_0000);
    idle(4);        check("R9 external drive ignored", rdata, 32'h0000_0000);

    // R8 external latency on pin 4
    pad_i = 32'h14;
    idle(3); check("R8 external not yet", rdata, 32'h0000_0000);
    idle(1); check("R8 external after sync", rdata, 32'h0000_0010);

    // R5 reset again
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R5 pad_oe after reset", pad_oe, 32'h0);
    rd(6'd8, v); check("R5 cfg pin0 after reset", v, 32'h2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule